// File: doc/BRIEF.md
# Indirect Control Register Port with Interrupt

This block is the host-facing slave side of a serial link peripheral. A processor reaches all of the peripheral's control and status registers through two ports. It picks the port with a single address line while chip select is low. Writing the index port selects a register. The data port then reads or writes that register. Each access is acknowledged with a ready handshake that follows the data strobe. All host inputs are brought into the system clock domain through two-stage synchronizers before they are used.

Five status flags record link events: missed frame, memory error, receive done, transmit done and primitive event. Software clears a flag by writing a one to it. The interrupt output is the OR of the flags, gated by an enable bit. After reset the block sits idle with its power-off bit set, and it ignores events until software clears that bit. Two further registers hold the pin-personality settings that other logic consumes: the bus-control mode, the address-strobe polarity, the burst-release input enable, and the modem pin selections.

The host side is a strobe handshake, not a valid/ready stream. The host holds chip select, the data strobe, direction and write data steady until `rdy` rises. It then drops the strobe or chip select and waits for `rdy` to fall before it starts the next access. There is no back-pressure beyond this handshake.

Top module: `regport_top`

## Requirements
- R1: After reset `power_off` is 1. The flags, the interrupt enable, all configuration outputs, `irq`, `rdy` and `dout_en` are 0, and the index is 0.
- R2: A write with `adr`=1 loads din[2:0] into the register index. A read with `adr`=1 returns the index in dout[2:0], with the upper bits zero.
- R3: `rdy` rises on the third rising clock edge after both `cs_n` and `ds_n` are low. It stays high while both stay low. It falls on the third rising edge after either one goes high.
- R4: For a read (`rd`=1) with `adr`=0, `dout` holds the selected register while `rdy` is high, and `dout_en` is high exactly then. For a write, `dout_en` stays 0.
- R5: Register 0 has the flags in bits 4:0 (bit 0 missed frame, bit 1 memory error, bit 2 receive done, bit 3 transmit done, bit 4 primitive event), the interrupt enable in bit 6 and the power-off bit in bit 7. Writing a 1 to a flag bit clears that flag, and writing a 0 leaves it unchanged. Bits 6 and 7 take the written value.
- R6: A high on `events[i]` sets flag i at the next rising edge when `power_off` is 0. While `power_off` is 1 the event is ignored. If an event and a clearing write land on the same edge, the event wins.
- R7: `irq` is high when the interrupt enable is 1 and any flag is set. It falls in the cycle after the last pending flag is cleared or the enable is written to 0.
- R8: Register 1 bit 0 drives `bus_mode`, bit 1 drives `strobe_pol` and bit 2 drives `brel_en`. Register 2 bit 0 drives `cts_mode` and bit 1 drives `rts_mode`. Unused bits read as 0.
- R9: Indices 3 to 7 read as 0. Writes to them change no register.
- R10: A strobe held low performs exactly one access. A flag set by an event while a clearing write's strobe is still held stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| adr | input | 1 | Port select: 1 = index port, 0 = data port |
| ds_n | input | 1 | Data strobe, active low |
| rd | input | 1 | Direction: 1 = host read, 0 = host write |
| din | input | 16 | Write data from the host |
| dout | output | 16 | Read data to the host |
| dout_en | output | 1 | Block drives dout (read acknowledged) |
| rdy | output | 1 | Access acknowledge |
| events | input | 5 | Status event pulses, one per flag |
| irq | output | 1 | Interrupt, active high |
| power_off | output | 1 | Idle/powered-off status |
| bus_mode | output | 1 | Bus-control pin mode select |
| strobe_pol | output | 1 | Address-strobe polarity select |
| brel_en | output | 1 | Burst-release input enable |
| cts_mode | output | 1 | Modem input pin behaviour select |
| rts_mode | output | 1 | Modem output pin behaviour select |

## Verification
A change on the host strobe or chip select shows up on `rdy` three rising edges later: two synchronizer stages plus the acknowledge register. Each access therefore samples `rdy` on the falling edges after the second and third rising edges, once when the strobe is asserted and again when it is released. Read data, register updates and configuration outputs change on the same edge as the rising `rdy`, so they are checked at the falling edge where `rdy` is first seen high, or at any later idle point. An event pulse sets its flag one edge after it is driven, so `irq` is compared one falling edge after each pulse.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int DW      = 16;
  localparam int IW      = 3;
  localparam int NFLAG   = 5;
  localparam int NSYNC   = 4;
  localparam int IDX_CTL = 0;
  localparam int IDX_BUS = 1;
  localparam int IDX_MDM = 2;
  localparam int BIT_IEN = 6;
  localparam int BIT_OFF = 7;
  localparam int NBUS    = 3;
  localparam int NMDM    = 2;
endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/regport_hshk.sv
module regport_hshk (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic ds_s,
  input  logic rd_s,
  output logic wr_stb,
  output logic rd_stb,
  output logic rdy,
  output logic rd_hold
);
  logic sel;
  logic acc;

  assign sel    = cs_s & ds_s;
  assign acc    = sel & ~rdy;
  assign wr_stb = acc & ~rd_s;
  assign rd_stb = acc & rd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy     <= 1'b0;
      rd_hold <= 1'b0;
    end else begin
      rdy <= sel;
      if (acc) rd_hold <= rd_s;
    end
  end

  p_rdy_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(cs_s && ds_s));
  p_rdy_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !(cs_s && ds_s)) |=> !rdy);
endmodule

// File: rtl/regport_regs.sv
module regport_regs
  import regport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic             adr_s,
  input  logic [DW-1:0]    din,
  input  logic [NFLAG-1:0] events,
  output logic [DW-1:0]    rdata,
  output logic [NFLAG-1:0] flags,
  output logic             ien,
  output logic             poff,
  output logic [NBUS-1:0]  bus_cfg,
  output logic [NMDM-1:0]  mdm_cfg
);
  logic [IW-1:0]    idx;
  logic [NFLAG-1:0] flags_nx;
  logic [DW-1:0]    sel_val;
  logic             data_wr;

  assign data_wr = wr_stb & ~adr_s;

  always_comb begin
    flags_nx = flags;
    if (data_wr && idx == IW'(IDX_CTL)) flags_nx = flags_nx & ~din[NFLAG-1:0];
    if (!poff) flags_nx = flags_nx | events;
  end

  always_comb begin
    sel_val = '0;
    case (idx)
      IW'(IDX_CTL): begin
        sel_val[NFLAG-1:0] = flags;
        sel_val[BIT_IEN]   = ien;
        sel_val[BIT_OFF]   = poff;
      end
      IW'(IDX_BUS): sel_val[NBUS-1:0] = bus_cfg;
      IW'(IDX_MDM): sel_val[NMDM-1:0] = mdm_cfg;
      default:      sel_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      flags   <= '0;
      ien     <= 1'b0;
      poff    <= 1'b1;
      bus_cfg <= '0;
      mdm_cfg <= '0;
      rdata   <= '0;
    end else begin
      flags <= flags_nx;
      if (wr_stb && adr_s) idx <= din[IW-1:0];
      if (data_wr) begin
        case (idx)
          IW'(IDX_CTL): begin
            ien  <= din[BIT_IEN];
            poff <= din[BIT_OFF];
          end
          IW'(IDX_BUS): bus_cfg <= din[NBUS-1:0];
          IW'(IDX_MDM): mdm_cfg <= din[NMDM-1:0];
          default: ;
        endcase
      end
      if (rd_stb) rdata <= adr_s ? DW'(idx) : sel_val;
    end
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag_chk
    p_flag_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !events[i] |=> !$rose(flags[i]));
  end

  p_poff_write_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(poff));
  p_unimpl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !adr_s && idx > IW'(IDX_MDM)) |=> rdata == '0);
endmodule

// File: rtl/regport_top.sv
module regport_top
  import regport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             adr,
  input  logic             ds_n,
  input  logic             rd,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dout_en,
  output logic             rdy,
  input  logic [NFLAG-1:0] events,
  output logic             irq,
  output logic             power_off,
  output logic             bus_mode,
  output logic             strobe_pol,
  output logic             brel_en,
  output logic             cts_mode,
  output logic             rts_mode
);
  logic [NSYNC-1:0] raw, syn;
  logic             cs_s, ds_s, adr_s, rd_s;
  logic             wr_stb, rd_stb, rd_hold;
  logic [NFLAG-1:0] flags;
  logic             ien;
  logic [NBUS-1:0]  bus_cfg;
  logic [NMDM-1:0]  mdm_cfg;
  logic [DW-1:0]    rdata;

  assign raw = {~cs_n, ~ds_n, adr, rd};
  assign {cs_s, ds_s, adr_s, rd_s} = syn;

  regport_sync #(.W(NSYNC), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  regport_hshk u_hshk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .ds_s(ds_s), .rd_s(rd_s),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .rdy(rdy), .rd_hold(rd_hold)
  );

  regport_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .adr_s(adr_s), .din(din), .events(events), .rdata(rdata),
    .flags(flags), .ien(ien), .poff(power_off),
    .bus_cfg(bus_cfg), .mdm_cfg(mdm_cfg)
  );

  assign dout_en    = rdy & rd_hold;
  assign dout       = dout_en ? rdata : '0;
  assign irq        = ien & (|flags);
  assign bus_mode   = bus_cfg[0];
  assign strobe_pol = bus_cfg[1];
  assign brel_en    = bus_cfg[2];
  assign cts_mode   = mdm_cfg[0];
  assign rts_mode   = mdm_cfg[1];

  p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_stb));
endmodule

// File: tb/regport_top_test.sv
module regport_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, adr = 1'b0, ds_n = 1'b1, rd = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        dout_en, rdy, irq, power_off;
  logic [4:0]  events = '0;
  logic        bus_mode, strobe_pol, brel_en, cts_mode, rts_mode;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [2:0] m_idx;
  logic [4:0] m_flags;
  logic       m_ien, m_poff;
  logic [2:0] m_bus;
  logic [1:0] m_mdm;

  always #4 clk = ~clk;

  regport_top uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adr(adr), .ds_n(ds_n), .rd(rd),
    .din(din), .dout(dout), .dout_en(dout_en), .rdy(rdy), .events(events),
    .irq(irq), .power_off(power_off), .bus_mode(bus_mode),
    .strobe_pol(strobe_pol), .brel_en(brel_en), .cts_mode(cts_mode),
    .rts_mode(rts_mode)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_data();
    logic [15:0] v = '0;
    case (m_idx)
      3'd0: begin v[4:0] = m_flags; v[6] = m_ien; v[7] = m_poff; end
      3'd1: v[2:0] = m_bus;
      3'd2: v[1:0] = m_mdm;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic exp_irq();
    return m_ien & (|m_flags);
  endfunction

  task automatic model_write(input bit a, input logic [15:0] d);
    if (a) m_idx = d[2:0];
    else case (m_idx)
      3'd0: begin m_flags = m_flags & ~d[4:0]; m_ien = d[6]; m_poff = d[7]; end
      3'd1: m_bus = d[2:0];
      3'd2: m_mdm = d[1:0];
      default: ;
    endcase
  endtask

  task automatic check_outs();
    check(irq == exp_irq(), "R7 irq", irq, exp_irq());
    check(power_off == m_poff, "R5 power_off", power_off, m_poff);
    check({brel_en, strobe_pol, bus_mode} == m_bus, "R8 bus cfg",
          {brel_en, strobe_pol, bus_mode}, m_bus);
    check({rts_mode, cts_mode} == m_mdm, "R8 modem cfg", {rts_mode, cts_mode}, m_mdm);
  endtask

  // one complete host access; rdy timing checked on both edges (R3)
  task automatic access(input bit a, input bit r, input logic [15:0] d, output logic [15:0] q);
    @(negedge clk);
    cs_n = 1'b0; adr = a; rd = r; din = d; ds_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(rdy == 1'b0, "R3 rdy early", rdy, 0);
    @(negedge clk);
    check(rdy == 1'b1, "R3 rdy rise", rdy, 1);
    check(dout_en == r, "R4 dout_en", dout_en, r);
    q = dout;
    if (!r) model_write(a, d);
    ds_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(rdy == 1'b1, "R3 rdy hold", rdy, 1);
    @(negedge clk);
    check(rdy == 1'b0, "R3 rdy fall", rdy, 0);
    check(dout_en == 1'b0, "R4 dout_en idle", dout_en, 0);
  endtask

  task automatic wr(input bit a, input logic [15:0] d);
    logic [15:0] q;
    access(a, 1'b0, d, q);
  endtask

  task automatic rd_chk(input bit a, input string req);
    logic [15:0] q, e;
    e = a ? {13'd0, m_idx} : exp_data();
    access(a, 1'b1, 16'h0, q);
    check(q == e, req, q, e);
  endtask

  task automatic pulse(input logic [4:0] ev);
    @(negedge clk);
    events = ev;
    @(negedge clk);
    events = '0;
    if (!m_poff) m_flags = m_flags | ev;
    check(irq == exp_irq(), "R6 R7 irq after event", irq, exp_irq());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_idx = 0; m_flags = 0; m_ien = 0; m_poff = 1; m_bus = 0; m_mdm = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(power_off == 1'b1, "R1 power_off", power_off, 1);
    check(irq == 1'b0 && rdy == 1'b0 && dout_en == 1'b0, "R1 irq/rdy", {irq, rdy, dout_en}, 0);
    check_outs();
    rd_chk(1'b1, "R1 R2 index after reset");
    rd_chk(1'b0, "R1 R5 reg0 after reset");

    // R6: events ignored while powered off
    pulse(5'b11111);
    rd_chk(1'b0, "R6 ignored while off");

    // power on, enable interrupt
    wr(1'b0, 16'h0040);
    check_outs();
    pulse(5'b00100);
    rd_chk(1'b0, "R5 flag set");
    // R5 write 0 leaves flag, clear with 1
    wr(1'b0, 16'h0040);
    rd_chk(1'b0, "R5 zero write keeps flag");
    check(irq == 1'b1, "R7 irq pending", irq, 1);
    wr(1'b0, 16'h0044);
    @(negedge clk);
    check(irq == 1'b0, "R7 irq cleared", irq, 0);

    // R6 set wins over same-edge clear: event pulse held over the access edge
    pulse(5'b01000);
    @(negedge clk);
    cs_n = 1'b0; adr = 1'b0; rd = 1'b0; din = 16'h0048; ds_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    events = 5'b01000;           // present at the access edge
    @(negedge clk);
    events = '0;
    check(rdy == 1'b1, "R6 rdy", rdy, 1);
    // R10: new event while strobe still held must survive
    pulse(5'b00001);
    m_flags = 5'b01001;
    repeat (3) @(negedge clk);
    check(rdy == 1'b1, "R10 rdy held", rdy, 1);
    ds_n = 1'b1; cs_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk(1'b0, "R6 R10 flags after held strobe");

    // R9 unimplemented indices
    wr(1'b1, 16'h0001); wr(1'b0, 16'h0005);
    wr(1'b1, 16'h0002); wr(1'b0, 16'h0003);
    for (int k = 3; k < 8; k++) begin
      wr(1'b1, 16'(k));
      wr(1'b0, 16'hFFFF);
      rd_chk(1'b0, "R9 unimplemented reads zero");
    end
    wr(1'b1, 16'h0001); rd_chk(1'b0, "R8 R9 reg1 untouched");
    wr(1'b1, 16'h0002); rd_chk(1'b0, "R8 R9 reg2 untouched");
    check_outs();

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom % 5;
      case (op)
        0: wr(1'b1, 16'($urandom % 8));
        1: begin
             logic [15:0] d = 16'($urandom);
             if (m_idx == 0 && ($urandom % 4) != 0) d[7] = 1'b0;
             wr(1'b0, d);
           end
        2: rd_chk(1'b0, "R4 R5 R8 random readback");
        3: rd_chk(1'b1, "R2 index readback");
        default: pulse(5'($urandom));
      endcase
      check_outs();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule